// File: doc/BRIEF.md
# Bus Target Burst Address Sequencer

This block is the front end of a simplified 32-bit PCI target. It watches the multiplexed address/data bus and the command/byte-enable lines during the single address phase that opens each transaction. It decodes the four-bit command and decides whether to claim the transaction. When it claims, it loads the start word address into a counter and then runs the target handshake. That handshake drives a device-select and a target-ready output, both active low. The counter advances by one 32-bit word on every completed data phase.

For each completed data phase the block issues one registered local read or write strobe. The strobe comes with the word address, the byte enables and the write data of that phase. The block also reports the transfer extent implied by the command, based on a 32-byte (eight-word) cache line. A line read raises a line-end marker when it reaches the last word of a line. A write-and-invalidate burst that finishes off a line boundary raises an error pulse.

Memory commands are claimed only inside a base/size window set by parameters. I/O and configuration commands are always claimed. Unknown command codes are never claimed.

Top module: `tgt_burst_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled high, `tgt_sel_n` and `tgt_rdy_n` are 1 and every local strobe (`lcl_rd_stb`, `lcl_wr_stb`, `lcl_line_end`, `lcl_mwi_err`) is 0.
- R2: An address phase is a clock where `bus_cyc_n` is sampled 0 after having been 1. These command codes on `cmd_be_n` are recognised: 0010 I/O read, 0011 I/O write, 0110 memory read, 0111 memory write, 1010 config read, 1011 config write, 1100 read multiple, 1110 read line, 1111 write-and-invalidate. A claimed command drives `tgt_sel_n` and `tgt_rdy_n` to 0 from the cycle after the address phase. `tgt_rdy_n` is never 0 while `tgt_sel_n` is 1.
- R3: Any other command code is not claimed. `tgt_sel_n` stays 1 and no local strobe is issued until the bus is idle (`bus_cyc_n` and `init_rdy_n` both 1).
- R4: The memory commands (0110, 0111, 1100, 1110, 1111) are claimed only when the address lies in [BASE_ADDR, BASE_ADDR + 2^WIN_LOG2). I/O and config commands are claimed at any address.
- R5: A data phase completes on a clock where `init_rdy_n` and `tgt_rdy_n` are both 0. One cycle later exactly one strobe is high: `lcl_wr_stb` for commands with bit 0 = 1, `lcl_rd_stb` otherwise. With the strobe come `lcl_addr` (the word address), `lcl_be` (the inverse of `cmd_be_n`) and `lcl_wdata` (the `ad_in` value of that phase).
- R6: The first strobe's `lcl_addr` equals `ad_in[31:2]` of the address phase. Each later strobe in the same transaction is one higher. Clocks where `init_rdy_n` is 1 (wait states) produce no strobe and do not advance the counter.
- R7: A data phase completed with `bus_cyc_n` = 1 is the final one. On the next cycle `tgt_sel_n` and `tgt_rdy_n` are 1, and a new address phase may follow.
- R8: `xfer_ext` is valid from the cycle after a claimed address phase: 1 for read line (one line), 2 for read multiple (several lines), 3 for write-and-invalidate (whole lines), 0 for all other commands.
- R9: For a read-line transaction, `lcl_line_end` is high together with the strobe whose `lcl_addr[2:0]` is 7, and low otherwise.
- R10: For write-and-invalidate, `lcl_mwi_err` is high together with the final strobe when that strobe's `lcl_addr[2:0]` is not 7, and low otherwise.
- R11: `lcl_space` gives the address space of the claimed command: 0 memory, 1 I/O, 2 configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 32 | Multiplexed address/data bus |
| cmd_be_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| bus_cyc_n | input | 1 | Initiator cycle-framing signal, active low |
| init_rdy_n | input | 1 | Initiator ready, active low |
| tgt_sel_n | output | 1 | Target claims the transaction, active low |
| tgt_rdy_n | output | 1 | Target ready, active low |
| lcl_rd_stb | output | 1 | Local read strobe, one cycle per completed phase |
| lcl_wr_stb | output | 1 | Local write strobe, one cycle per completed phase |
| lcl_addr | output | 30 | Local word address of the strobed phase |
| lcl_be | output | 4 | Active-high byte enables of the strobed phase |
| lcl_wdata | output | 32 | Data of the strobed phase |
| lcl_space | output | 2 | Address space of the transaction |
| xfer_ext | output | 2 | Transfer extent code of the command |
| lcl_line_end | output | 1 | Read-line strobe reached the last word of a line |
| lcl_mwi_err | output | 1 | Write-and-invalidate ended off a line boundary |

## Verification
The assertions assume that the initiator follows the bus protocol. The framing signal is released only together with, or after, initiator ready is asserted for the last phase. Initiator ready is not withdrawn in the middle of a phase. An aborted, unclaimed transaction ends with both signals high. The bench drives every transaction from one task that obeys these rules. It always leaves an idle cycle between transactions, so each address phase is seen as a fresh falling edge of the framing signal. For unclaimed commands it performs a master-abort sequence rather than waiting for a handshake that never comes.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
  localparam logic [3:0] CMD_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_WR_INV  = 4'b1111;

  typedef enum logic [1:0] {
    SP_MEM = 2'd0,
    SP_IO  = 2'd1,
    SP_CFG = 2'd2
  } space_t;

  typedef enum logic [1:0] {
    EXT_PLAIN = 2'd0,
    EXT_LINE  = 2'd1,
    EXT_MULTI = 2'd2,
    EXT_WHOLE = 2'd3
  } ext_t;

  typedef struct packed {
    logic   known;
    logic   is_mem;
    logic   is_write;
    space_t space;
    ext_t   ext;
  } cmd_info_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } seq_state_t;

endpackage

// File: rtl/tgt_cmd_dec.sv
module tgt_cmd_dec
  import tgt_seq_pkg::*;
(
  input  logic [3:0] code,
  output cmd_info_t  info
);

  always_comb begin
    info          = '0;
    info.is_write = code[0];
    info.space    = SP_MEM;
    info.ext      = EXT_PLAIN;
    case (code)
      CMD_IO_RD, CMD_IO_WR: begin
        info.known = 1'b1;
        info.space = SP_IO;
      end
      CMD_CFG_RD, CMD_CFG_WR: begin
        info.known = 1'b1;
        info.space = SP_CFG;
      end
      CMD_MEM_RD, CMD_MEM_WR: begin
        info.known  = 1'b1;
        info.is_mem = 1'b1;
      end
      CMD_RD_MULT: begin
        info.known  = 1'b1;
        info.is_mem = 1'b1;
        info.ext    = EXT_MULTI;
      end
      CMD_RD_LINE: begin
        info.known  = 1'b1;
        info.is_mem = 1'b1;
        info.ext    = EXT_LINE;
      end
      CMD_WR_INV: begin
        info.known  = 1'b1;
        info.is_mem = 1'b1;
        info.ext    = EXT_WHOLE;
      end
      default: info = '0;
    endcase
  end

endmodule

// File: rtl/tgt_word_ctr.sv
module tgt_word_ctr #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              adv,
  output logic [WORD_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (adv)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tgt_burst_seq.sv
module tgt_burst_seq
  import tgt_seq_pkg::*;
#(
  parameter int          AD_W       = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h8000_0000,
  parameter int          WIN_LOG2   = 16,
  parameter int          LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AD_W-1:0]   ad_in,
  input  logic [3:0]        cmd_be_n,
  input  logic              bus_cyc_n,
  input  logic              init_rdy_n,
  output logic              tgt_sel_n,
  output logic              tgt_rdy_n,
  output logic              lcl_rd_stb,
  output logic              lcl_wr_stb,
  output logic [AD_W-3:0]   lcl_addr,
  output logic [3:0]        lcl_be,
  output logic [AD_W-1:0]   lcl_wdata,
  output logic [1:0]        lcl_space,
  output logic [1:0]        xfer_ext,
  output logic              lcl_line_end,
  output logic              lcl_mwi_err
);

  localparam int WORD_W     = AD_W - 2;
  localparam int LINE_WORDS = LINE_BYTES / 4;
  localparam int LINE_LSB   = $clog2(LINE_WORDS);

  seq_state_t  state;
  cmd_info_t   info, info_q;
  logic        frame_q;
  logic        addr_phase, win_hit, claim, hs, last_word;
  logic [WORD_W-1:0] cnt;

  tgt_cmd_dec u_dec (
    .code (cmd_be_n),
    .info (info)
  );

  assign addr_phase = (state == ST_IDLE) && !bus_cyc_n && frame_q;
  assign win_hit    = ad_in[AD_W-1:WIN_LOG2] == BASE_ADDR[AD_W-1:WIN_LOG2];
  assign claim      = info.known && (!info.is_mem || win_hit);
  assign hs         = (state == ST_DATA) && !init_rdy_n && !tgt_rdy_n;
  assign last_word  = &cnt[LINE_LSB-1:0];

  tgt_word_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (addr_phase),
    .load_val (ad_in[AD_W-1:2]),
    .adv      (hs),
    .cnt      (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      frame_q      <= 1'b1;
      info_q       <= '0;
      tgt_sel_n    <= 1'b1;
      tgt_rdy_n    <= 1'b1;
      lcl_rd_stb   <= 1'b0;
      lcl_wr_stb   <= 1'b0;
      lcl_addr     <= '0;
      lcl_be       <= '0;
      lcl_wdata    <= '0;
      lcl_space    <= '0;
      xfer_ext     <= '0;
      lcl_line_end <= 1'b0;
      lcl_mwi_err  <= 1'b0;
    end else begin
      frame_q      <= bus_cyc_n;
      lcl_rd_stb   <= 1'b0;
      lcl_wr_stb   <= 1'b0;
      lcl_line_end <= 1'b0;
      lcl_mwi_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (addr_phase) begin
            info_q <= info;
            if (claim) begin
              state     <= ST_DATA;
              tgt_sel_n <= 1'b0;
              tgt_rdy_n <= 1'b0;
              lcl_space <= info.space;
              xfer_ext  <= info.ext;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (hs) begin
            lcl_wr_stb   <= info_q.is_write;
            lcl_rd_stb   <= !info_q.is_write;
            lcl_addr     <= cnt;
            lcl_be       <= ~cmd_be_n;
            lcl_wdata    <= ad_in;
            lcl_line_end <= (info_q.ext == EXT_LINE) && last_word;
            lcl_mwi_err  <= (info_q.ext == EXT_WHOLE) && bus_cyc_n && !last_word;
            if (bus_cyc_n) begin
              state     <= ST_IDLE;
              tgt_sel_n <= 1'b1;
              tgt_rdy_n <= 1'b1;
            end
          end
        end
        ST_SKIP: begin
          if (bus_cyc_n && init_rdy_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertion support: the last strobed address within the current transaction
  logic              seen_stb;
  logic [WORD_W-1:0] prev_addr;
  logic              stb;
  assign stb = lcl_rd_stb || lcl_wr_stb;

  always_ff @(posedge clk) begin
    if (rst || addr_phase) begin
      seen_stb  <= 1'b0;
      prev_addr <= '0;
    end else if (stb) begin
      seen_stb  <= 1'b1;
      prev_addr <= lcl_addr;
    end
  end

  // R2
  rdy_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !tgt_rdy_n |-> !tgt_sel_n);

  // R3
  unknown_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_phase && !info.known) |=> (tgt_sel_n && !stb));

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    hs |=> (lcl_rd_stb != lcl_wr_stb));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && seen_stb) |-> (lcl_addr == prev_addr + 1'b1));

  // R7
  final_release_chk: assert property (@(posedge clk) disable iff (rst)
    (hs && bus_cyc_n) |=> (tgt_sel_n && tgt_rdy_n));

  // R9
  line_end_chk: assert property (@(posedge clk) disable iff (rst)
    lcl_line_end |-> (lcl_rd_stb && (&lcl_addr[LINE_LSB-1:0])));

  // R10
  mwi_err_chk: assert property (@(posedge clk) disable iff (rst)
    lcl_mwi_err |-> (lcl_wr_stb && tgt_sel_n && !(&lcl_addr[LINE_LSB-1:0])));

endmodule

// File: tb/tgt_burst_seq_tb.sv
module tgt_burst_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam int WLOG = 16;
  localparam int NVEC = 14;

  // {cmd[3:0], addr[31:0], beats[7:0], waits[3:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {4'b0110, 32'h8000_0010, 8'd1,  4'd0},  // single memory read
    {4'b0111, 32'h8000_0100, 8'd4,  4'd1},  // memory write, waits
    {4'b1110, 32'h8000_0020, 8'd8,  4'd0},  // full line read
    {4'b1110, 32'h8000_0030, 8'd4,  4'd2},  // line read from mid line
    {4'b1100, 32'h8000_0040, 8'd16, 4'd0},  // two-line read multiple
    {4'b1111, 32'h8000_0080, 8'd8,  4'd1},  // aligned write-invalidate
    {4'b1111, 32'h8000_00A0, 8'd5,  4'd0},  // short write-invalidate
    {4'b0010, 32'h0000_1000, 8'd2,  4'd0},  // I/O read outside window
    {4'b1011, 32'h0000_0004, 8'd1,  4'd0},  // config write
    {4'b0110, 32'h9000_0000, 8'd1,  4'd0},  // above window
    {4'b0001, 32'h8000_0000, 8'd1,  4'd0},  // unknown code
    {4'b0111, 32'h8000_FFFC, 8'd1,  4'd0},  // top word of window
    {4'b0110, 32'h7FFF_FFFC, 8'd1,  4'd0},  // below window
    {4'b0011, 32'h0000_2000, 8'd3,  4'd1}   // I/O write, waits
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cmd_be_n = 4'hF;
  logic        bus_cyc_n = 1'b1;
  logic        init_rdy_n = 1'b1;
  logic        tgt_sel_n, tgt_rdy_n, lcl_rd_stb, lcl_wr_stb;
  logic [29:0] lcl_addr;
  logic [3:0]  lcl_be;
  logic [31:0] lcl_wdata;
  logic [1:0]  lcl_space, xfer_ext;
  logic        lcl_line_end, lcl_mwi_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgt_burst_seq #(.BASE_ADDR(BASE), .WIN_LOG2(WLOG)) u_dut (
    .clk(clk), .rst(rst), .ad_in(ad_in), .cmd_be_n(cmd_be_n),
    .bus_cyc_n(bus_cyc_n), .init_rdy_n(init_rdy_n),
    .tgt_sel_n(tgt_sel_n), .tgt_rdy_n(tgt_rdy_n),
    .lcl_rd_stb(lcl_rd_stb), .lcl_wr_stb(lcl_wr_stb),
    .lcl_addr(lcl_addr), .lcl_be(lcl_be), .lcl_wdata(lcl_wdata),
    .lcl_space(lcl_space), .xfer_ext(xfer_ext),
    .lcl_line_end(lcl_line_end), .lcl_mwi_err(lcl_mwi_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [3:0] c);
    return c inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF};
  endfunction

  function automatic bit is_memc(input logic [3:0] c);
    return c inside {4'h6, 4'h7, 4'hC, 4'hE, 4'hF};
  endfunction

  function automatic logic [1:0] ext_of(input logic [3:0] c);
    case (c)
      4'hE: return 2'd1;
      4'hC: return 2'd2;
      4'hF: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] space_of(input logic [3:0] c);
    if (c == 4'h2 || c == 4'h3) return 2'd1;
    if (c == 4'hA || c == 4'hB) return 2'd2;
    return 2'd0;
  endfunction

  task automatic idle_bus();
    bus_cyc_n  = 1'b1;
    init_rdy_n = 1'b1;
    cmd_be_n   = 4'hF;
    ad_in      = '0;
  endtask

  task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr,
                         input int beats, input int waits);
    bit claim;
    bit wr;
    logic [29:0] wa;
    claim = is_known(cmd) &&
            (!is_memc(cmd) || (addr[31:WLOG] == BASE[31:WLOG]));
    wr = cmd[0];
    @(negedge clk);
    bus_cyc_n = 1'b0; init_rdy_n = 1'b1; ad_in = addr; cmd_be_n = cmd;
    @(negedge clk);
    if (!claim) begin
      chk(tgt_sel_n == 1'b1, is_known(cmd) ? "R4 out-of-window not claimed"
                                           : "R3 unknown not claimed",
          tgt_sel_n, 1);
      bus_cyc_n = 1'b1; init_rdy_n = 1'b0; cmd_be_n = 4'h0;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(tgt_sel_n && !lcl_rd_stb && !lcl_wr_stb, "R3 no strobe when unclaimed",
            {tgt_sel_n, lcl_rd_stb, lcl_wr_stb}, 3'b100);
      end
      idle_bus();
      @(negedge clk);
      return;
    end
    chk(!tgt_sel_n && !tgt_rdy_n, "R2 claim after address phase",
        {tgt_sel_n, tgt_rdy_n}, 2'b00);
    chk(xfer_ext == ext_of(cmd), "R8 extent code", xfer_ext, ext_of(cmd));
    for (int i = 0; i < beats; i++) begin
      for (int w = 0; w < waits; w++) begin
        bus_cyc_n = 1'b0; init_rdy_n = 1'b1; ad_in = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(!lcl_rd_stb && !lcl_wr_stb, "R6 no strobe in wait state",
            {lcl_rd_stb, lcl_wr_stb}, 2'b00);
      end
      bus_cyc_n  = (i == beats - 1);
      init_rdy_n = 1'b0;
      cmd_be_n   = i[3:0] ^ 4'hA;
      ad_in      = 32'hD000_0000 + i;
      @(negedge clk);
      wa = addr[31:2] + 30'(i);
      chk(lcl_wr_stb == wr && lcl_rd_stb == !wr, "R5 strobe kind",
          {lcl_rd_stb, lcl_wr_stb}, {!wr, wr});
      chk(lcl_addr == wa, "R6 word address", lcl_addr, wa);
      chk(lcl_be == ~(i[3:0] ^ 4'hA), "R5 byte enables", lcl_be, ~(i[3:0] ^ 4'hA));
      if (wr) chk(lcl_wdata == 32'hD000_0000 + i, "R5 write data", lcl_wdata,
                  32'hD000_0000 + i);
      chk(lcl_space == space_of(cmd), "R11 space code", lcl_space, space_of(cmd));
      chk(lcl_line_end == (cmd == 4'hE && wa[2:0] == 3'd7), "R9 line end",
          lcl_line_end, (cmd == 4'hE && wa[2:0] == 3'd7));
      chk(lcl_mwi_err == (cmd == 4'hF && i == beats - 1 && wa[2:0] != 3'd7),
          "R10 misaligned write-invalidate", lcl_mwi_err,
          (cmd == 4'hF && i == beats - 1 && wa[2:0] != 3'd7));
      if (i == beats - 1) begin
        chk(tgt_sel_n && tgt_rdy_n, "R7 release after final phase",
            {tgt_sel_n, tgt_rdy_n}, 2'b11);
        idle_bus();
      end else begin
        chk(!tgt_sel_n, "R7 held during burst", tgt_sel_n, 0);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tgt_sel_n && tgt_rdy_n && !lcl_rd_stb && !lcl_wr_stb && !lcl_line_end
        && !lcl_mwi_err, "R1 reset state",
        {tgt_sel_n, tgt_rdy_n, lcl_rd_stb, lcl_wr_stb}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_txn(VEC[v][47:44], VEC[v][43:12], int'(VEC[v][11:4]), int'(VEC[v][3:0]));

    // R1: reset in the middle of a burst releases the bus
    @(negedge clk);
    bus_cyc_n = 1'b0; init_rdy_n = 1'b1; ad_in = 32'h8000_0200; cmd_be_n = 4'b0111;
    @(negedge clk);
    init_rdy_n = 1'b0; cmd_be_n = 4'h0; ad_in = 32'h1234_5678;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(tgt_sel_n && tgt_rdy_n && !lcl_wr_stb && !lcl_rd_stb,
        "R1 reset mid burst", {tgt_sel_n, tgt_rdy_n, lcl_wr_stb}, 3'b110);
    idle_bus();
    rst = 1'b0;
    @(negedge clk);

    // R7: a new transaction is accepted right after a reset-aborted one
    run_txn(4'b0110, 32'h8000_0008, 2, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule